// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the purely combinational control for an in-order scalar pipeline with five stages (fetch, decode, execute, memory, writeback) and a side path for a pipelined multiplier. The multiplier is `MUL_STAGES` stages deep and writes back through the writeback stage. Each cycle the block looks at the decoded fields held in the decode, execute, memory and writeback latches and in the first `MUL_STAGES-1` multiply latches. From these it chooses where each execute-stage operand comes from: the memory-stage result, the writeback value, or the register file. It also decides whether a store in the memory stage takes its data from the load in writeback.

The same logic decides whether decode must wait. A wait is needed for a load-to-use dependence, for a read of a register that an in-flight multiply will produce, for a clash on the single register-file write port, and to keep writes to the same register in program order behind a slow multiply. When the execute stage resolves a mispredicted branch, the block kills the two younger instructions. A kill always wins over a wait.

The datapath applies the outputs at the next clock edge. A wait holds the PC and the decode latch and puts a bubble into execute. A kill puts bubbles into both decode and execute.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: `fwd_a_o` is 0 when `x_rs1_i` equals the memory-stage destination while that stage writes. Otherwise it is 1 when `x_rs1_i` equals the writeback destination while that stage writes. Otherwise it is 2. A memory-stage match wins over a writeback match.
- R2: `fwd_b_o` follows the same rule as R1, using `x_rs2_i`.
- R3: Register 0 never causes a forward, a store-data bypass or a wait. Neither does a destination whose write-enable bit is clear. A decoder marks an unused source by giving it register 0.
- R4: Operation codes are 0 nop, 1 ALU, 2 load, 3 store, 4 multiply and 5 branch. `st_data_fwd_o` is 1 exactly when the memory stage holds a store (3) and writeback holds a writing load (2) whose destination equals the store's data register `m_rs2_i`.
- R5: Take a valid decode instruction while execute holds a writing load. If the decode first source equals the load destination, the block waits. If the decode second source equals it and the decode instruction is not a store, the block also waits. A wait is `hold_o`=1, `nop_x_o`=1 and `nop_d_o`=0.
- R6: A valid decode instruction waits when either of its sources equals the destination of a writing entry in any of multiply latches 0 to `MUL_STAGES-2`.
- R7: A valid decode instruction that is not a multiply and writes a register waits while multiply latch `MUL_STAGES-3` (latch 1 by default) writes a register. A decode multiply does not wait for this reason.
- R8: A valid non-multiply decode instruction waits when its destination equals the destination of a writing entry in a multiply latch below `MUL_STAGES-3` (latch 0 by default).
- R9: When `x_br_resolved_i` and `x_br_mispred_i` are both 1, `nop_d_o` and `nop_x_o` are 1 and `hold_o` is 0, whatever hazards are present. A mispredict flag that arrives without the resolved flag does nothing.
- R10: With no hazard and no kill, `hold_o`, `nop_d_o` and `nop_x_o` are all 0. An invalid decode slot never waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_valid_i | input | 1 | Decode latch holds an instruction |
| d_op_i | input | 3 | Decode operation code |
| d_rs1_i | input | REG_W | Decode first source |
| d_rs2_i | input | REG_W | Decode second source (store data for stores) |
| d_rd_i | input | REG_W | Decode destination |
| d_rd_we_i | input | 1 | Decode destination is written |
| x_op_i | input | 3 | Execute operation code |
| x_rs1_i | input | REG_W | Execute first source |
| x_rs2_i | input | REG_W | Execute second source |
| x_rd_i | input | REG_W | Execute destination |
| x_rd_we_i | input | 1 | Execute destination is written |
| x_br_resolved_i | input | 1 | Branch in execute resolved this cycle |
| x_br_mispred_i | input | 1 | Resolved branch was mispredicted |
| m_op_i | input | 3 | Memory-stage operation code |
| m_rs2_i | input | REG_W | Memory-stage store data register |
| m_rd_i | input | REG_W | Memory-stage destination |
| m_rd_we_i | input | 1 | Memory-stage destination is written |
| w_op_i | input | 3 | Writeback operation code |
| w_rd_i | input | REG_W | Writeback destination |
| w_rd_we_i | input | 1 | Writeback destination is written |
| p_rd_i | input | (MUL_STAGES-1)*REG_W | Destinations of multiply latches, latch k at bits k*REG_W |
| p_rd_we_i | input | MUL_STAGES-1 | Write-enable of each multiply latch |
| fwd_a_o | output | 2 | Operand A source select |
| fwd_b_o | output | 2 | Operand B source select |
| st_data_fwd_o | output | 1 | Store data taken from writeback |
| hold_o | output | 1 | Hold PC and decode latch |
| nop_d_o | output | 1 | Load a bubble into decode |
| nop_x_o | output | 1 | Load a bubble into execute |

## Verification
The block holds no state, so any fault in its decode logic shows at the ports in the same cycle as the input pattern that exposes it. A wrong operand select or store-data bypass becomes a wrong value for one instruction and does not halt anything. A wrong wait is more serious. A missing wait lets a dependent or reordered write through. An extra wait costs cycles and can lock the pipeline if it never clears. A wait that is not overridden by a kill lets a wrong-path instruction survive. The bench compares every output every cycle, over directed cases for each rule and over dense random traffic on a small register range so that matches are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALU    = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_MUL    = 3'd4,
    OP_BRANCH = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SEL_MEM = 2'd0,
    SEL_WB  = 2'd1,
    SEL_RF  = 2'd2
  } fwd_sel_e;

  localparam int OP_W = 3;
  // cycles from entering execute to writeback on the ALU path
  localparam int ALU_TO_W = 3;
endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] m_rd_i,
  input  logic             m_rd_we_i,
  input  logic [REG_W-1:0] w_rd_i,
  input  logic             w_rd_we_i,
  output fwd_sel_e         sel_o
);
  logic m_hit, w_hit;

  assign m_hit = m_rd_we_i && (m_rd_i != '0) && (m_rd_i == src_i);
  assign w_hit = w_rd_we_i && (w_rd_i != '0) && (w_rd_i == src_i);

  always_comb begin
    if (m_hit)      sel_o = SEL_MEM;
    else if (w_hit) sel_o = SEL_WB;
    else            sel_o = SEL_RF;
  end
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [OP_W-1:0]  m_op_i,
  input  logic [REG_W-1:0] m_rs2_i,
  input  logic [OP_W-1:0]  w_op_i,
  input  logic [REG_W-1:0] w_rd_i,
  input  logic             w_rd_we_i,
  output logic             st_fwd_o
);
  logic m_is_st, w_is_ld;

  assign m_is_st  = op_e'(m_op_i) == OP_STORE;
  assign w_is_ld  = op_e'(w_op_i) == OP_LOAD;
  assign st_fwd_o = m_is_st && w_is_ld && w_rd_we_i &&
                    (w_rd_i != '0) && (w_rd_i == m_rs2_i);
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int MUL_STAGES = 4
) (
  input  logic                             d_valid_i,
  input  logic [OP_W-1:0]                  d_op_i,
  input  logic [REG_W-1:0]                 d_rs1_i,
  input  logic [REG_W-1:0]                 d_rs2_i,
  input  logic [REG_W-1:0]                 d_rd_i,
  input  logic                             d_rd_we_i,
  input  logic [OP_W-1:0]                  x_op_i,
  input  logic [REG_W-1:0]                 x_rd_i,
  input  logic                             x_rd_we_i,
  input  logic [(MUL_STAGES-1)*REG_W-1:0]  p_rd_i,
  input  logic [MUL_STAGES-2:0]            p_rd_we_i,
  output logic                             hazard_o
);
  localparam int NUM_P    = MUL_STAGES - 1;
  // multiply latch that reaches writeback together with an ALU op leaving decode now
  localparam int PORT_IDX = MUL_STAGES - ALU_TO_W;

  op_e              d_op, x_op;
  logic             d_writes, x_load_live, load_use;
  logic [NUM_P-1:0] raw_hit, port_hit, waw_hit;

  assign d_op = op_e'(d_op_i);
  assign x_op = op_e'(x_op_i);

  assign d_writes    = d_rd_we_i && (d_rd_i != '0) && (d_op != OP_MUL);
  assign x_load_live = (x_op == OP_LOAD) && x_rd_we_i && (x_rd_i != '0);
  assign load_use    = x_load_live &&
                       ((d_rs1_i == x_rd_i) ||
                        ((d_rs2_i == x_rd_i) && (d_op != OP_STORE)));

  for (genvar k = 0; k < NUM_P; k++) begin : g_p
    logic [REG_W-1:0] rd_k;
    logic             live_k;
    assign rd_k       = p_rd_i[k*REG_W +: REG_W];
    assign live_k     = p_rd_we_i[k] && (rd_k != '0);
    assign raw_hit[k] = live_k && ((d_rs1_i == rd_k) || (d_rs2_i == rd_k));
    if (k == PORT_IDX) begin : g_port
      assign port_hit[k] = live_k && d_writes;
    end else begin : g_noport
      assign port_hit[k] = 1'b0;
    end
    if (k < PORT_IDX) begin : g_waw
      assign waw_hit[k] = live_k && d_writes && (rd_k == d_rd_i);
    end else begin : g_nowaw
      assign waw_hit[k] = 1'b0;
    end
  end

  assign hazard_o = d_valid_i && (load_use || (|raw_hit) || (|port_hit) || (|waw_hit));
endmodule

// File: rtl/hz_ctl_arb.sv
module hz_ctl_arb (
  input  logic hazard_i,
  input  logic br_resolved_i,
  input  logic br_mispred_i,
  output logic hold_o,
  output logic nop_d_o,
  output logic nop_x_o
);
  logic kill;

  assign kill    = br_resolved_i && br_mispred_i;
  // kill overrides hold: the held instruction is on the wrong path
  assign hold_o  = hazard_i && !kill;
  assign nop_d_o = kill;
  assign nop_x_o = hazard_i || kill;
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hz_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int MUL_STAGES = 4
) (
  input  logic                            d_valid_i,
  input  logic [2:0]                      d_op_i,
  input  logic [REG_W-1:0]                d_rs1_i,
  input  logic [REG_W-1:0]                d_rs2_i,
  input  logic [REG_W-1:0]                d_rd_i,
  input  logic                            d_rd_we_i,
  input  logic [2:0]                      x_op_i,
  input  logic [REG_W-1:0]                x_rs1_i,
  input  logic [REG_W-1:0]                x_rs2_i,
  input  logic [REG_W-1:0]                x_rd_i,
  input  logic                            x_rd_we_i,
  input  logic                            x_br_resolved_i,
  input  logic                            x_br_mispred_i,
  input  logic [2:0]                      m_op_i,
  input  logic [REG_W-1:0]                m_rs2_i,
  input  logic [REG_W-1:0]                m_rd_i,
  input  logic                            m_rd_we_i,
  input  logic [2:0]                      w_op_i,
  input  logic [REG_W-1:0]                w_rd_i,
  input  logic                            w_rd_we_i,
  input  logic [(MUL_STAGES-1)*REG_W-1:0] p_rd_i,
  input  logic [MUL_STAGES-2:0]           p_rd_we_i,
  output logic [1:0]                      fwd_a_o,
  output logic [1:0]                      fwd_b_o,
  output logic                            st_data_fwd_o,
  output logic                            hold_o,
  output logic                            nop_d_o,
  output logic                            nop_x_o
);
  localparam int NUM_OPND = 2;

  logic [REG_W-1:0] opnd_src [NUM_OPND];
  fwd_sel_e         opnd_sel [NUM_OPND];
  logic             hazard;

  assign opnd_src[0] = x_rs1_i;
  assign opnd_src[1] = x_rs2_i;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_operand_fwd #(.REG_W(REG_W)) u_fwd (
      .src_i     (opnd_src[g]),
      .m_rd_i    (m_rd_i),
      .m_rd_we_i (m_rd_we_i),
      .w_rd_i    (w_rd_i),
      .w_rd_we_i (w_rd_we_i),
      .sel_o     (opnd_sel[g])
    );
  end

  assign fwd_a_o = opnd_sel[0];
  assign fwd_b_o = opnd_sel[1];

  hz_store_fwd #(.REG_W(REG_W)) u_st (
    .m_op_i    (m_op_i),
    .m_rs2_i   (m_rs2_i),
    .w_op_i    (w_op_i),
    .w_rd_i    (w_rd_i),
    .w_rd_we_i (w_rd_we_i),
    .st_fwd_o  (st_data_fwd_o)
  );

  hz_stall_unit #(.REG_W(REG_W), .MUL_STAGES(MUL_STAGES)) u_stall (
    .d_valid_i (d_valid_i),
    .d_op_i    (d_op_i),
    .d_rs1_i   (d_rs1_i),
    .d_rs2_i   (d_rs2_i),
    .d_rd_i    (d_rd_i),
    .d_rd_we_i (d_rd_we_i),
    .x_op_i    (x_op_i),
    .x_rd_i    (x_rd_i),
    .x_rd_we_i (x_rd_we_i),
    .p_rd_i    (p_rd_i),
    .p_rd_we_i (p_rd_we_i),
    .hazard_o  (hazard)
  );

  hz_ctl_arb u_arb (
    .hazard_i      (hazard),
    .br_resolved_i (x_br_resolved_i),
    .br_mispred_i  (x_br_mispred_i),
    .hold_o        (hold_o),
    .nop_d_o       (nop_d_o),
    .nop_x_o       (nop_x_o)
  );
endmodule

module pipe_hazard_ctl_chk
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             d_valid_i,
  input logic [REG_W-1:0] x_rs1_i,
  input logic [REG_W-1:0] x_rs2_i,
  input logic             x_br_resolved_i,
  input logic             x_br_mispred_i,
  input logic [2:0]       m_op_i,
  input logic [2:0]       w_op_i,
  input logic [REG_W-1:0] w_rd_i,
  input logic             w_rd_we_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             st_data_fwd_o,
  input logic             hold_o,
  input logic             nop_d_o,
  input logic             nop_x_o
);
  always_comb begin
    // R9
    flush_wins_chk: assert (!(hold_o && nop_d_o));
    // R5
    stall_bubble_chk: assert (!hold_o || nop_x_o);
    // R1
    fwd_a_zero_chk: assert (fwd_a_o == SEL_RF || x_rs1_i != '0);
    // R2
    fwd_b_wb_chk: assert (fwd_b_o != SEL_WB || (w_rd_we_i && w_rd_i == x_rs2_i));
    // R4
    st_fwd_kind_chk: assert (!st_data_fwd_o || (m_op_i == OP_STORE && w_op_i == OP_LOAD));
    // R10
    quiet_chk: assert (d_valid_i || (x_br_resolved_i && x_br_mispred_i) || (!hold_o && !nop_x_o));
  end
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
  .d_valid_i       (d_valid_i),
  .x_rs1_i         (x_rs1_i),
  .x_rs2_i         (x_rs2_i),
  .x_br_resolved_i (x_br_resolved_i),
  .x_br_mispred_i  (x_br_mispred_i),
  .m_op_i          (m_op_i),
  .w_op_i          (w_op_i),
  .w_rd_i          (w_rd_i),
  .w_rd_we_i       (w_rd_we_i),
  .fwd_a_o         (fwd_a_o),
  .fwd_b_o         (fwd_b_o),
  .st_data_fwd_o   (st_data_fwd_o),
  .hold_o          (hold_o),
  .nop_d_o         (nop_d_o),
  .nop_x_o         (nop_x_o)
);

// File: tb/sim_pipe_hazard_ctl.sv
module sim_pipe_hazard_ctl;
  localparam int RW = 5;
  localparam int NP = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          d_valid, d_rd_we, x_rd_we, x_res, x_mis, m_rd_we, w_rd_we;
  logic [2:0]    d_op, x_op, m_op, w_op;
  logic [RW-1:0] d_rs1, d_rs2, d_rd, x_rs1, x_rs2, x_rd, m_rs2, m_rd, w_rd;
  logic [NP*RW-1:0] p_rd;
  logic [NP-1:0] p_we;
  logic [1:0]    fwd_a, fwd_b;
  logic          st_fwd, hold, nop_d, nop_x;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pipe_hazard_ctl #(.REG_W(RW), .MUL_STAGES(4)) u0 (
    .d_valid_i(d_valid), .d_op_i(d_op), .d_rs1_i(d_rs1), .d_rs2_i(d_rs2),
    .d_rd_i(d_rd), .d_rd_we_i(d_rd_we),
    .x_op_i(x_op), .x_rs1_i(x_rs1), .x_rs2_i(x_rs2), .x_rd_i(x_rd),
    .x_rd_we_i(x_rd_we), .x_br_resolved_i(x_res), .x_br_mispred_i(x_mis),
    .m_op_i(m_op), .m_rs2_i(m_rs2), .m_rd_i(m_rd), .m_rd_we_i(m_rd_we),
    .w_op_i(w_op), .w_rd_i(w_rd), .w_rd_we_i(w_rd_we),
    .p_rd_i(p_rd), .p_rd_we_i(p_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .st_data_fwd_o(st_fwd),
    .hold_o(hold), .nop_d_o(nop_d), .nop_x_o(nop_x)
  );

  int e_a, e_b, e_st, e_hold, e_nd, e_nx;

  function automatic int pick(int src);
    if (m_rd_we && m_rd != 0 && int'(m_rd) == src) return 0;
    if (w_rd_we && w_rd != 0 && int'(w_rd) == src) return 1;
    return 2;
  endfunction

  function automatic int prd(int k);
    return int'(p_rd[k*RW +: RW]);
  endfunction

  task automatic model();
    bit haz = 0;
    bit kill;
    e_a  = pick(int'(x_rs1));
    e_b  = pick(int'(x_rs2));
    e_st = (m_op == 3 && w_op == 2 && w_rd_we && w_rd != 0 && w_rd == m_rs2) ? 1 : 0;
    if (d_valid) begin
      if (x_op == 2 && x_rd_we && x_rd != 0 &&
          (d_rs1 == x_rd || (d_rs2 == x_rd && d_op != 3))) haz = 1;
      for (int k = 0; k < NP; k++) begin
        if (p_we[k] && prd(k) != 0 && (prd(k) == int'(d_rs1) || prd(k) == int'(d_rs2))) haz = 1;
      end
      if (d_op != 4 && d_rd_we && d_rd != 0) begin
        if (p_we[1] && prd(1) != 0) haz = 1;
        if (p_we[0] && prd(0) == int'(d_rd)) haz = 1;
      end
    end
    kill   = x_res && x_mis;
    e_hold = (haz && !kill) ? 1 : 0;
    e_nd   = kill ? 1 : 0;
    e_nx   = (haz || kill) ? 1 : 0;
  endtask

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, name, act, exp);
    end
  endtask

  task automatic step(string tag_fwd, string tag_ctl);
    @(negedge clk);
    model();
    chk(tag_fwd == "" ? "R1" : tag_fwd, "fwd_a", int'(fwd_a), e_a);
    chk(tag_fwd == "" ? "R2" : tag_fwd, "fwd_b", int'(fwd_b), e_b);
    chk(tag_fwd == "" ? "R4" : tag_fwd, "st_fwd", int'(st_fwd), e_st);
    chk(tag_ctl, "hold", int'(hold), e_hold);
    chk(tag_ctl, "nop_d", int'(nop_d), e_nd);
    chk(tag_ctl, "nop_x", int'(nop_x), e_nx);
  endtask

  task automatic clear();
    d_valid = 0; d_op = 0; d_rs1 = 0; d_rs2 = 0; d_rd = 0; d_rd_we = 0;
    x_op = 0; x_rs1 = 0; x_rs2 = 0; x_rd = 0; x_rd_we = 0; x_res = 0; x_mis = 0;
    m_op = 0; m_rs2 = 0; m_rd = 0; m_rd_we = 0;
    w_op = 0; w_rd = 0; w_rd_we = 0; p_rd = '0; p_we = '0;
  endtask

  task automatic set_p(int k, int rd, bit we);
    p_rd[k*RW +: RW] = RW'(rd);
    p_we[k] = we;
  endtask

  initial begin
    clear();
    // R10 idle state
    step("R10", "R10");
    chk("R10", "idle fwd_a", int'(fwd_a), 2);
    chk("R10", "idle hold", int'(hold), 0);
    // R1 memory match wins over writeback
    x_rs1 = 5; m_rd = 5; m_rd_we = 1; w_rd = 5; w_rd_we = 1;
    step("R1", "R10");
    chk("R1", "m priority", int'(fwd_a), 0);
    m_rd_we = 0;
    step("R1", "R10");
    chk("R1", "w select", int'(fwd_a), 1);
    // R2
    clear(); x_rs2 = 7; m_rd = 7; m_rd_we = 1;
    step("R2", "R10");
    chk("R2", "m select b", int'(fwd_b), 0);
    m_rd = 6; w_rd = 7; w_rd_we = 1;
    step("R2", "R10");
    // R3 register 0 and cleared enables
    clear(); x_rs1 = 0; m_rd = 0; m_rd_we = 1; w_rd = 0; w_rd_we = 1;
    step("R3", "R3");
    x_rs1 = 4; m_rd = 4; m_rd_we = 0; w_rd = 4; w_rd_we = 0;
    step("R3", "R3");
    chk("R3", "no enable", int'(fwd_a), 2);
    d_valid = 1; d_op = 1; x_op = 2; x_rd = 0; x_rd_we = 1;
    step("R3", "R3");
    // R4 store data bypass
    clear(); m_op = 3; m_rs2 = 9; w_op = 2; w_rd = 9; w_rd_we = 1;
    step("R4", "R10");
    chk("R4", "st bypass", int'(st_fwd), 1);
    w_op = 1;
    step("R4", "R10");
    chk("R4", "alu no bypass", int'(st_fwd), 0);
    // R5 load-use
    clear(); x_op = 2; x_rd = 3; x_rd_we = 1; d_valid = 1; d_op = 1; d_rs1 = 3;
    step("", "R5");
    chk("R5", "lu hold", int'(hold), 1);
    d_rs1 = 0; d_rs2 = 3; d_op = 3;
    step("", "R5");
    chk("R5", "store data no hold", int'(hold), 0);
    d_op = 1;
    step("", "R5");
    d_valid = 0;
    step("", "R10");
    // R6 multiply RAW
    clear(); d_valid = 1; d_op = 1; d_rs2 = 4; set_p(2, 4, 1);
    step("", "R6");
    chk("R6", "p2 raw", int'(hold), 1);
    set_p(2, 4, 0); set_p(0, 4, 1);
    step("", "R6");
    // R7 write port
    clear(); d_valid = 1; d_op = 1; d_rd = 8; d_rd_we = 1; set_p(1, 6, 1);
    step("", "R7");
    chk("R7", "port hold", int'(hold), 1);
    d_op = 4;
    step("", "R7");
    chk("R7", "mul no hold", int'(hold), 0);
    // R8 write order
    clear(); d_valid = 1; d_op = 1; d_rd = 8; d_rd_we = 1; set_p(0, 8, 1);
    step("", "R8");
    chk("R8", "waw hold", int'(hold), 1);
    set_p(0, 9, 1);
    step("", "R8");
    d_op = 4; set_p(0, 8, 1);
    step("", "R8");
    // R9 kill beats hold
    clear(); d_valid = 1; d_op = 1; d_rs1 = 3; x_op = 2; x_rd = 3; x_rd_we = 1;
    x_res = 1; x_mis = 1;
    step("", "R9");
    chk("R9", "kill hold", int'(hold), 0);
    chk("R9", "kill nop_d", int'(nop_d), 1);
    x_res = 0;
    step("", "R9");
    // random traffic on a narrow register range
    for (int i = 0; i < 4000; i++) begin
      d_valid = ($urandom_range(0, 7) != 0);
      d_op = 3'($urandom_range(0, 5)); x_op = 3'($urandom_range(0, 5));
      m_op = 3'($urandom_range(0, 5)); w_op = 3'($urandom_range(0, 5));
      d_rs1 = RW'($urandom_range(0, 3)); d_rs2 = RW'($urandom_range(0, 3));
      d_rd  = RW'($urandom_range(0, 3)); x_rs1 = RW'($urandom_range(0, 3));
      x_rs2 = RW'($urandom_range(0, 3)); x_rd  = RW'($urandom_range(0, 3));
      m_rs2 = RW'($urandom_range(0, 3)); m_rd  = RW'($urandom_range(0, 3));
      w_rd  = RW'($urandom_range(0, 3));
      d_rd_we = ($urandom_range(0, 3) != 0); x_rd_we = ($urandom_range(0, 3) != 0);
      m_rd_we = ($urandom_range(0, 3) != 0); w_rd_we = ($urandom_range(0, 3) != 0);
      for (int k = 0; k < NP; k++) set_p(k, $urandom_range(0, 3), $urandom_range(0, 2) == 0);
      x_res = ($urandom_range(0, 3) == 0); x_mis = ($urandom_range(0, 1) == 0);
      step("", "R5-9");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule